// File: doc/BRIEF.md
# Ethernet PHY Clock Generator

This block derives the clocks that an Ethernet MAC needs toward its PHY from a single control word. Software writes a 32-bit value over a one-cycle synchronous write strobe. The block picks one of two source clocks. It divides that source by a programmable integer. It then divides again by a fixed ratio of 5 or 10 to form the PHY reference clock and the transmit clock. In RMII mode the transmit clock can be inverted. In RGMII mode the block also provides a copy of the transmit clock that is shifted by a programmable number of quarter periods.

The whole block runs on one system clock. Each source clock is presented as a one-cycle tick stream, where a tick marks one rising edge of that source. All divided outputs are registered levels in the system clock domain. The source selection is only meant to change while the generator is disabled. Every write to the control word restarts both divider counters, so a new ratio starts on a clean period boundary.

Top module: `eth_clkgen`

## Requirements
- R1: After reset the control word is zero, so the generator is disabled. `phy_ref_clk`, `tx_clk`, `tx_clk_dly` and `mode_rgmii` are all 0.
- R2: Control bit 0 selects the interface mode (1 = RGMII, 0 = RMII). `mode_rgmii` follows this bit two clocks after the write.
- R3: Control bit 4 selects the source tick stream: 0 selects `src_tick[0]` and 1 selects `src_tick[1]`.
- R4: Control bits 9:7 hold the pre-divide ratio N, one-based, so the value 3 divides by 3. The value 0 is accepted and acts as divide-by-1.
- R5: Control bit 10 picks the final ratio M: 5 when clear, 10 when set. With source period P system cycles, `phy_ref_clk` is high for floor(M/2)·N·P cycles and low for the remaining (M−floor(M/2))·N·P cycles.
- R6: Control bit 11 inverts `tx_clk` relative to `phy_ref_clk`, but only in RMII mode. In RGMII mode the bit is ignored and `tx_clk` equals `phy_ref_clk`.
- R7: Control bit 12 enables the generator. While it is clear, `phy_ref_clk`, `tx_clk` and `tx_clk_dly` stay low.
- R8: Control bits 6:5 hold a delay code f. In RGMII mode, each rising edge of `tx_clk_dly` follows a rising edge of `phy_ref_clk` by floor(f·M/4) pre-divided ticks, which is floor(f·M/4)·N·P system cycles. In RMII mode the code has no effect and `tx_clk_dly` equals `phy_ref_clk`.
- R9: Every write restarts both divider counters. After a write, the enabled `phy_ref_clk` begins a new high phase two clocks later, even if the write lands in the middle of a low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word value |
| src_tick | input | 2 | One tick per rising edge of each source clock |
| mode_rgmii | output | 1 | Registered interface mode (1 = RGMII) |
| phy_ref_clk | output | 1 | Divided PHY reference clock |
| tx_clk | output | 1 | Transmit clock, optionally inverted in RMII mode |
| tx_clk_dly | output | 1 | Transmit clock shifted by the programmed quarter steps in RGMII mode |

## Verification
Some rules are checked by assertions on every cycle:
- both counters stay within their current ratios;
- a write forces the final counter to zero;
- the outputs go low one clock after the enable drops;
- in RGMII mode `tx_clk` matches `phy_ref_clk`;
- in RMII mode the delayed clock matches the reference.

Other behaviour only shows up when the bench drives a configuration and measures the clock that results:
- the high and low widths for each source, pre-divide and final ratio;
- the treatment of a zero pre-divide value;
- the rise-to-rise delay offsets;
- the inversion in RMII mode;
- the phase restart on a mid-period write.

// File: rtl/eth_clkgen_pkg.sv
package eth_clkgen_pkg;

  // Control word layout. These positions are decoded by software and must stay fixed.
  localparam int CTRL_WIDTH  = 32;
  localparam int MODE_POS    = 0;
  localparam int SRC_POS     = 4;
  localparam int DLY_LSB     = 5;
  localparam int DLY_WIDTH   = 2;
  localparam int PDIV_LSB    = 7;
  localparam int PDIV_WIDTH  = 3;
  localparam int FSEL_POS    = 10;
  localparam int INV_POS     = 11;
  localparam int EN_POS      = 12;

  // Final stage ratios
  localparam int FIN_RATIO_LO = 5;
  localparam int FIN_RATIO_HI = 10;

  typedef struct packed {
    logic                  en;
    logic                  inv;
    logic                  fsel;
    logic [PDIV_WIDTH-1:0] pdiv;
    logic [DLY_WIDTH-1:0]  dly;
    logic                  src;
    logic                  rgmii;
  } ctrl_t;

endpackage

// File: rtl/eth_clkgen_rst_sync.sv
module eth_clkgen_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  // Assert asynchronously, release on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/eth_clkgen_regs.sv
module eth_clkgen_regs
  import eth_clkgen_pkg::*;
#(
  parameter int CTRL_W = CTRL_WIDTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output ctrl_t             ctrl,
  output logic              restart
);

  ctrl_t ctrl_q;
  ctrl_t ctrl_d;
  ctrl_t wr_fields;
  logic  unused_bits;

  always_comb begin
    wr_fields.en    = wr_data[EN_POS];
    wr_fields.inv   = wr_data[INV_POS];
    wr_fields.fsel  = wr_data[FSEL_POS];
    wr_fields.pdiv  = wr_data[PDIV_LSB +: PDIV_WIDTH];
    wr_fields.dly   = wr_data[DLY_LSB +: DLY_WIDTH];
    wr_fields.src   = wr_data[SRC_POS];
    wr_fields.rgmii = wr_data[MODE_POS];
  end

  // Bits with no defined meaning are dropped
  assign unused_bits = ^{wr_data[CTRL_W-1:EN_POS+1], wr_data[SRC_POS-1:MODE_POS+1]};

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = wr_fields;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl    = ctrl_q;
  assign restart = wr_en;

endmodule

// File: rtl/eth_clkgen_prediv.sv
module eth_clkgen_prediv #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic             tick_in,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick_out
);

  logic [DIV_W-1:0] last_cnt;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;

  // One-based ratio; a zero field behaves like a ratio of one
  always_comb begin
    if (div_val == '0) last_cnt = '0;
    else               last_cnt = div_val - DIV_W'(1);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!en || restart)   cnt_d = '0;
    else if (tick_in) begin
      if (cnt_q == last_cnt) cnt_d = '0;
      else                   cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_out = en && tick_in && (cnt_q == last_cnt);

  AST_PDIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_cnt);  // R4

endmodule

// File: rtl/eth_clkgen_final.sv
module eth_clkgen_final #(
  parameter int DLY_W  = 2,
  parameter int FIN_LO = 5,
  parameter int FIN_HI = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             rgmii,
  input  logic             inv,
  input  logic             fsel,
  input  logic [DLY_W-1:0] dly,
  input  logic             restart,
  input  logic             tick_in,
  output logic             ref_clk_o,
  output logic             tx_clk_o,
  output logic             tx_dly_o,
  output logic             mode_o
);

  localparam int CNT_W  = $clog2(FIN_HI + 1);
  localparam int PROD_W = CNT_W + DLY_W;

  logic [CNT_W-1:0]  ratio;
  logic [CNT_W-1:0]  high_len;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_d;
  logic [PROD_W-1:0] dly_prod;
  logic [CNT_W-1:0]  dly_cnt;
  logic [CNT_W:0]    phase;
  logic              base_hi;
  logic              shift_hi;
  logic              ref_d, tx_d, dly_d, mode_d;
  logic              ref_q, tx_q, dly_q, mode_q;

  always_comb begin
    ratio    = fsel ? CNT_W'(FIN_HI) : CNT_W'(FIN_LO);
    high_len = ratio >> 1;
  end

  // Final counter: advances once per pre-divided tick
  always_comb begin
    cnt_d = cnt_q;
    if (!en || restart) cnt_d = '0;
    else if (tick_in) begin
      if (cnt_q == ratio - CNT_W'(1)) cnt_d = '0;
      else                            cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // The delayed clock reuses the counter: it compares against a lagging phase
  always_comb begin
    dly_prod = PROD_W'(dly) * PROD_W'(ratio);
    dly_cnt  = rgmii ? CNT_W'(dly_prod >> 2) : '0;
    if (cnt_q >= dly_cnt) phase = {1'b0, cnt_q} - {1'b0, dly_cnt};
    else                  phase = {1'b0, cnt_q} + {1'b0, ratio} - {1'b0, dly_cnt};
  end

  always_comb begin
    base_hi  = cnt_q < high_len;
    shift_hi = phase < {1'b0, high_len};
    ref_d    = en && base_hi;
    tx_d     = en && ((inv && !rgmii) ? !base_hi : base_hi);
    dly_d    = en && shift_hi;
    mode_d   = rgmii;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= 1'b0;
      tx_q   <= 1'b0;
      dly_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      ref_q  <= ref_d;
      tx_q   <= tx_d;
      dly_q  <= dly_d;
      mode_q <= mode_d;
    end
  end

  assign ref_clk_o = ref_q;
  assign tx_clk_o  = tx_q;
  assign tx_dly_o  = dly_q;
  assign mode_o    = mode_q;

  AST_FIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio);  // R5

  AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));  // R9

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!ref_q && !tx_q && !dly_q));  // R7

  AST_RGMII_NO_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> (tx_q == ref_q));  // R6

  AST_RMII_NO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> (dly_q == ref_q));  // R8

endmodule

// File: rtl/eth_clkgen.sv
module eth_clkgen
  import eth_clkgen_pkg::*;
#(
  parameter int CTRL_W  = CTRL_WIDTH,
  parameter int NUM_SRC = 2,
  parameter int SYNC_ST = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic [NUM_SRC-1:0] src_tick,
  output logic              mode_rgmii,
  output logic              phy_ref_clk,
  output logic              tx_clk,
  output logic              tx_clk_dly
);

  logic  rst_s_n;
  ctrl_t ctrl;
  logic  restart;
  logic  sel_tick;
  logic  mid_tick;

  eth_clkgen_rst_sync #(.STAGES(SYNC_ST)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  eth_clkgen_regs #(.CTRL_W(CTRL_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctrl    (ctrl),
    .restart (restart)
  );

  // Source selection
  always_comb begin
    sel_tick = src_tick[ctrl.src];
  end

  eth_clkgen_prediv #(.DIV_W(PDIV_WIDTH)) u_prediv (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .en       (ctrl.en),
    .restart  (restart),
    .tick_in  (sel_tick),
    .div_val  (ctrl.pdiv),
    .tick_out (mid_tick)
  );

  eth_clkgen_final #(
    .DLY_W  (DLY_WIDTH),
    .FIN_LO (FIN_RATIO_LO),
    .FIN_HI (FIN_RATIO_HI)
  ) u_final (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .en        (ctrl.en),
    .rgmii     (ctrl.rgmii),
    .inv       (ctrl.inv),
    .fsel      (ctrl.fsel),
    .dly       (ctrl.dly),
    .restart   (restart),
    .tick_in   (mid_tick),
    .ref_clk_o (phy_ref_clk),
    .tx_clk_o  (tx_clk),
    .tx_dly_o  (tx_clk_dly),
    .mode_o    (mode_rgmii)
  );

endmodule

// File: tb/sim_eth_clkgen.sv
module sim_eth_clkgen;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [1:0]  src_tick;
  logic        mode_rgmii, phy_ref_clk, tx_clk, tx_clk_dly;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    string tag;
    bit    is_offset;
    int    exp_a;
    int    exp_b;
  } item_t;

  item_t exp_q[$];
  int    pushed = 0;
  int    served = 0;

  eth_clkgen u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .src_tick    (src_tick),
    .mode_rgmii  (mode_rgmii),
    .phy_ref_clk (phy_ref_clk),
    .tx_clk      (tx_clk),
    .tx_clk_dly  (tx_clk_dly)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Source 0 ticks every cycle; source 1 ticks every second cycle
  initial begin
    src_tick = 2'b01;
    forever begin
      @(negedge clk);
      src_tick[1] = ~src_tick[1];
    end
  end

  function automatic logic [31:0] cfg(bit rg, bit src, int dly, int pdiv, bit fsel, bit inv, bit en);
    logic [31:0] v;
    v = '0;
    v[0]    = rg;
    v[4]    = src;
    v[6:5]  = 2'(dly);
    v[9:7]  = 3'(pdiv);
    v[10]   = fsel;
    v[11]   = inv;
    v[12]   = en;
    return v;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_cfg(logic [31:0] v);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // Driver side: push an expected item and wait for the monitor to consume it
  task automatic expect_item(string tag, bit is_off, int a, int b);
    item_t it;
    it.tag = tag; it.is_offset = is_off; it.exp_a = a; it.exp_b = b;
    exp_q.push_back(it);
    pushed++;
    wait (served == pushed);
  endtask

  task automatic find_rise(output bit ok, output logic dly_before);
    logic pr;
    ok = 0;
    pr = phy_ref_clk;
    dly_before = tx_clk_dly;
    for (int i = 0; i < 2000; i++) begin
      dly_before = tx_clk_dly;
      @(negedge clk);
      if (phy_ref_clk && !pr) begin ok = 1; break; end
      pr = phy_ref_clk;
    end
  endtask

  // Monitor: pops expectations and measures the clock it sees
  initial begin
    item_t it;
    bit ok;
    logic pd;
    int hi, lo, off;
    forever begin
      wait (exp_q.size() != 0);
      it = exp_q.pop_front();
      find_rise(ok, pd);
      if (it.is_offset) begin
        find_rise(ok, pd);
        off = -1;
        if (ok) begin
          if (tx_clk_dly && !pd) off = 0;
          else begin
            for (int i = 1; i < 200; i++) begin
              pd = tx_clk_dly;
              @(negedge clk);
              if (tx_clk_dly && !pd) begin off = i; break; end
            end
          end
        end
        check(off == it.exp_a, {it.tag, " delay offset"}, off, it.exp_a);
      end else begin
        hi = 0; lo = 0;
        if (ok) begin
          hi = 1;
          for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!phy_ref_clk) break;
            hi++;
          end
          lo = 1;
          for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (phy_ref_clk) break;
            lo++;
          end
        end
        check(hi == it.exp_a, {it.tag, " high width"}, hi, it.exp_a);
        check(lo == it.exp_b, {it.tag, " low width"}, lo, it.exp_b);
      end
      served++;
    end
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int bad;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check({phy_ref_clk, tx_clk, tx_clk_dly} == 3'b000, "R1 clocks after reset",
          int'({phy_ref_clk, tx_clk, tx_clk_dly}), 0);
    check(mode_rgmii == 1'b0, "R1 mode after reset", int'(mode_rgmii), 0);

    // R7: configured but disabled stays low
    write_cfg(cfg(1, 0, 1, 1, 0, 0, 0));
    bad = 0;
    repeat (30) begin
      @(negedge clk);
      if (phy_ref_clk || tx_clk || tx_clk_dly) bad++;
    end
    check(bad == 0, "R7 disabled outputs low", bad, 0);

    // R5: final ratio 5 and 10, duty split
    write_cfg(cfg(0, 0, 0, 1, 0, 0, 1));
    expect_item("R5 ratio5 div1 srcA", 0, 2, 3);
    write_cfg(cfg(0, 0, 0, 1, 1, 0, 1));
    expect_item("R5 ratio10 div1 srcA", 0, 5, 5);

    // R4: pre-divide values, zero acts as one
    write_cfg(cfg(0, 0, 0, 0, 0, 0, 1));
    expect_item("R4 div0 bypass", 0, 2, 3);
    write_cfg(cfg(0, 0, 0, 3, 1, 0, 1));
    expect_item("R4 div3 ratio10", 0, 15, 15);
    write_cfg(cfg(0, 0, 0, 7, 0, 0, 1));
    expect_item("R4 div7 ratio5", 0, 14, 21);

    // R3: second source runs at half rate
    write_cfg(cfg(0, 1, 0, 2, 0, 0, 1));
    expect_item("R3 srcB div2 ratio5", 0, 8, 12);
    write_cfg(cfg(0, 1, 0, 0, 1, 0, 1));
    expect_item("R3 srcB div0 ratio10", 0, 10, 10);

    // R2: mode bit
    write_cfg(cfg(1, 0, 0, 1, 0, 0, 1));
    @(negedge clk);
    check(mode_rgmii == 1'b1, "R2 mode set", int'(mode_rgmii), 1);
    write_cfg(cfg(0, 0, 0, 1, 0, 0, 1));
    @(negedge clk);
    check(mode_rgmii == 1'b0, "R2 mode clear", int'(mode_rgmii), 0);

    // R6: inversion applies in RMII, ignored in RGMII
    write_cfg(cfg(0, 0, 0, 1, 0, 1, 1));
    repeat (3) @(negedge clk);
    bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (tx_clk != !phy_ref_clk) bad++;
    end
    check(bad == 0, "R6 RMII inverted", bad, 0);
    write_cfg(cfg(1, 0, 0, 1, 0, 1, 1));
    repeat (3) @(negedge clk);
    bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (tx_clk != phy_ref_clk) bad++;
    end
    check(bad == 0, "R6 RGMII ignores invert", bad, 0);

    // R8: quarter-step delay in RGMII, none in RMII
    write_cfg(cfg(1, 0, 1, 1, 0, 0, 1));
    expect_item("R8 code1 ratio5", 1, 1, 0);
    write_cfg(cfg(1, 0, 3, 1, 1, 0, 1));
    expect_item("R8 code3 ratio10", 1, 7, 0);
    write_cfg(cfg(1, 1, 2, 1, 0, 0, 1));
    expect_item("R8 code2 ratio5 srcB", 1, 4, 0);
    write_cfg(cfg(0, 0, 3, 1, 1, 0, 1));
    expect_item("R8 RMII code ignored", 1, 0, 0);

    // R9: a write inside a low phase starts a new high phase
    write_cfg(cfg(0, 0, 0, 1, 1, 0, 1));
    for (int i = 0; i < 100 && !phy_ref_clk; i++) @(negedge clk);
    for (int i = 0; i < 100 && phy_ref_clk; i++) @(negedge clk);
    wr_en   = 1'b1;
    wr_data = cfg(0, 0, 0, 1, 1, 0, 1);
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    check(phy_ref_clk == 1'b1, "R9 restart on write", int'(phy_ref_clk), 1);

    // R7: disabling after running forces outputs low
    write_cfg(cfg(0, 0, 0, 1, 0, 0, 0));
    @(negedge clk);
    bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (phy_ref_clk || tx_clk || tx_clk_dly) bad++;
    end
    check(bad == 0, "R7 disable after run", bad, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule